// File: doc/BRIEF.md
# Frame Pulse Tracker with Free-Run and Resync

This block follows a periodic frame-start pulse that arrives alongside a parallel-port receive clock and turns it into a registered local frame strobe and a time-slot counter for a TDM switching datapath. The counter runs over a fixed frame length given as a parameter. When pulses stop, the block keeps producing frame starts on its own at the same interval. When a pulse comes back, the block aligns to it on the next cycle, with no confirmation window.

A pulse that lands anywhere other than the expected frame boundary sets a sticky interrupt flag. Software clears the flag by writing one. A missing pulse never sets it. The transmit side has its own clock and its own slot counter. By default that counter free-runs. With the external-framing mode bit set, it tracks an external transmit pulse, free-running and resyncing in the same way as the receive side. A status bit then reports when the external pulse and a reference frame pulse disagree in phase. The transmit pulse never reaches the interrupt flag.

Top module: `frame_pulse_tracker`

## Requirements
- R1: While either reset input is low at a clock edge, that domain's slot counter goes to 0 and its frame strobe goes low. The receive reset also clears the interrupt flag, and the transmit reset also clears the phase status bit.
- R2: With no pulse present, each slot counter steps by one per clock and wraps from FRAME_LEN-1 to 0. The frame strobe is high for exactly the one cycle in which the counter has just wrapped to 0.
- R3: If the receive pulse is absent at the expected boundary, the counter wraps at the normal interval and the interrupt flag does not change.
- R4: A receive pulse sampled while the counter reads FRAME_LEN-1 keeps the timing unchanged and does not set the interrupt flag.
- R5: A receive pulse sampled at any other counter value makes the counter read 0, with the strobe high, on the next cycle. If a receive pulse has already been seen since reset, it also sets the interrupt flag one cycle later.
- R6: The first receive pulse after reset aligns the counter without setting the interrupt flag.
- R7: The interrupt flag stays set until a one-cycle clear write. It reads 0 on the cycle after the write, unless a misplaced pulse arrives in the same cycle as the write, in which case it stays 1.
- R8: While the receive pulse is held high, the counter stays at 0 and the strobe stays high on every cycle.
- R9: With the external-framing mode bit low, the transmit counter free-runs from reset, ignores the external transmit pulse, and the phase status bit reads 0 one cycle after the mode bit is low.
- R10: With the mode bit high, an external transmit pulse aligns the transmit counter to 0 on the next cycle. With no pulse, the counter free-runs. Transmit pulses never change the interrupt flag.
- R11: With the mode bit high, in any cycle where the external transmit pulse or the reference pulse is high, the phase status bit on the next cycle is 1 if exactly one of them is high and 0 if both are high. In all other cycles it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive clock |
| rx_rst_n | input | 1 | Synchronous active-low reset, receive domain |
| rx_fp | input | 1 | Receive frame pulse, active high |
| irq_clr | input | 1 | Clear write for the interrupt flag, one cycle, receive clock |
| rx_slot | output | SLOT_W | Receive time-slot counter |
| rx_frame | output | 1 | Registered receive frame strobe |
| move_irq | output | 1 | Sticky framing-change interrupt flag |
| tx_clk | input | 1 | Transmit clock |
| tx_rst_n | input | 1 | Synchronous active-low reset, transmit domain |
| ext_tx_en | input | 1 | External transmit framing mode bit |
| ext_tx_fp | input | 1 | External transmit frame pulse |
| ref_fp | input | 1 | Reference frame pulse, transmit clock |
| tx_slot | output | SLOT_W | Transmit time-slot counter |
| tx_frame | output | 1 | Registered transmit frame strobe |
| tx_phase_err | output | 1 | External pulse out of phase with reference |

## Verification
The assertions assume that every pulse, clear write and mode change is synchronous to its own clock and is sampled on the rising edge. They also assume that the reference pulse belongs to the transmit clock, so no checker ever compares signals across domains. The bench drives both clocks from one source and changes inputs two nanoseconds after each rising edge, so every input is stable around each edge. Pulse widths and placements are set explicitly, including held pulses and a pulse at every slot position. This covers on-time, misplaced, missing and stuck framing.

// File: rtl/fpt_pkg.sv
// Shared definitions for the frame pulse tracker.
// Assumes: nothing beyond IEEE 1800-2017.
package fpt_pkg;

    // Nominal frame length in receive-clock cycles when the top is not overridden.
    localparam int unsigned FPT_DEFAULT_LEN = 2430;

    // Classification of a sampled frame pulse against the local timing.
    typedef enum logic [1:0] {
        EV_NONE    = 2'd0,
        EV_FIRST   = 2'd1,
        EV_ON_TIME = 2'd2,
        EV_MOVED   = 2'd3
    } pulse_ev_t;

endpackage

// File: rtl/fpt_slot_timer.sv
// Slot counter with free-run and immediate resync.
// Counts 0..FRAME_LEN-1 and wraps on its own. A sampled pulse forces slot 0
// on the next cycle, whatever the current count. The strobe is registered and
// marks the cycle in which the counter reads 0 after a wrap or a pulse.
// Assumes: pulse_i is synchronous to clk; FRAME_LEN >= 2.
module fpt_slot_timer #(
    parameter int unsigned FRAME_LEN = 2430,
    parameter int unsigned SLOT_W    = $clog2(FRAME_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic              frame_o
);

    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_LEN - 1);

    logic at_last;

    // Detect the final slot of the frame.
    always_comb begin
        at_last = (slot_o == LAST);
    end

    // Advance, wrap or realign the slot counter and raise the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_o  <= '0;
            frame_o <= 1'b0;
        end else if (pulse_i || at_last) begin
            slot_o  <= '0;
            frame_o <= 1'b1;
        end else begin
            slot_o  <= slot_o + 1'b1;
            frame_o <= 1'b0;
        end
    end

    p_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_i |=> (slot_o == '0) && frame_o);

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_i && at_last) |=> (slot_o == '0) && frame_o);

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_i && !at_last) |=> (slot_o == SLOT_W'($past(slot_o) + 1'b1)) && !frame_o);

    p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_o <= LAST);

endmodule

// File: rtl/fpt_move_detect.sv
// Classifies each receive pulse against the local slot count.
// The first pulse after reset only establishes timing. Later pulses that do
// not fall on the last slot of the frame are reported as moved.
// Assumes: slot_i comes from the slot timer that this pulse also drives.
module fpt_move_detect
    import fpt_pkg::*;
#(
    parameter int unsigned FRAME_LEN = 2430,
    parameter int unsigned SLOT_W    = $clog2(FRAME_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic              moved_o
);

    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_LEN - 1);

    logic      acquired;
    pulse_ev_t ev;

    // Sort the current pulse into none, first, on-time or moved.
    always_comb begin
        if (!pulse_i)              ev = EV_NONE;
        else if (!acquired)        ev = EV_FIRST;
        else if (slot_i == LAST)   ev = EV_ON_TIME;
        else                       ev = EV_MOVED;
    end

    // Remember that timing has been taken from a pulse since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        acquired <= 1'b0;
        else if (pulse_i)  acquired <= 1'b1;
    end

    // Drive the moved indication from the classification.
    always_comb begin
        moved_o = (ev == EV_MOVED);
    end

    p_first_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        moved_o |-> $past(pulse_i) || acquired);

endmodule

// File: rtl/fpt_sticky_flag.sv
// Sticky flag that software clears by writing one. A set in the same cycle
// as a clear wins.
// Assumes: set_i and clr_i are synchronous to clk.
module fpt_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    // Hold, set or clear the flag.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (set_i)  flag_o <= 1'b1;
        else if (clr_i)  flag_o <= 1'b0;
    end

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(flag_o));

endmodule

// File: rtl/fpt_phase_check.sv
// Compares the external transmit pulse with the reference frame pulse.
// In any cycle with at least one pulse, the status is set to show whether
// exactly one pulse is present. With the mode off, the status is held at 0.
// Assumes: both pulses are synchronous to clk.
module fpt_phase_check (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic ext_i,
    input  logic ref_i,
    output logic err_o
);

    // Update the phase status whenever a pulse is seen.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i)     err_o <= 1'b0;
        else if (ext_i || ref_i) err_o <= ext_i ^ ref_i;
    end

    p_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && ext_i && ref_i) |=> !err_o);

    p_mismatch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (ext_i != ref_i)) |=> err_o);

    p_mode_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !err_o);

endmodule

// File: rtl/frame_pulse_tracker.sv
// Frame pulse tracker: receive slot timing with a framing-change interrupt,
// and transmit slot timing with optional external framing and a phase check.
// Assumes: irq_clr is on rx_clk; ext_tx_en, ext_tx_fp and ref_fp are on tx_clk.
module frame_pulse_tracker
    import fpt_pkg::*;
#(
    parameter int unsigned FRAME_LEN = FPT_DEFAULT_LEN,
    localparam int unsigned SLOT_W   = $clog2(FRAME_LEN)
) (
    input  logic              rx_clk,
    input  logic              rx_rst_n,
    input  logic              rx_fp,
    input  logic              irq_clr,
    output logic [SLOT_W-1:0] rx_slot,
    output logic              rx_frame,
    output logic              move_irq,
    input  logic              tx_clk,
    input  logic              tx_rst_n,
    input  logic              ext_tx_en,
    input  logic              ext_tx_fp,
    input  logic              ref_fp,
    output logic [SLOT_W-1:0] tx_slot,
    output logic              tx_frame,
    output logic              tx_phase_err
);

    logic rx_moved;
    logic tx_pulse;

    // Pass the external pulse to the transmit timer only in external mode.
    always_comb begin
        tx_pulse = ext_tx_en && ext_tx_fp;
    end

    fpt_slot_timer #(.FRAME_LEN(FRAME_LEN), .SLOT_W(SLOT_W)) u_rx_timer (
        .clk     (rx_clk),
        .rst_n   (rx_rst_n),
        .pulse_i (rx_fp),
        .slot_o  (rx_slot),
        .frame_o (rx_frame)
    );

    fpt_move_detect #(.FRAME_LEN(FRAME_LEN), .SLOT_W(SLOT_W)) u_rx_move (
        .clk     (rx_clk),
        .rst_n   (rx_rst_n),
        .pulse_i (rx_fp),
        .slot_i  (rx_slot),
        .moved_o (rx_moved)
    );

    fpt_sticky_flag u_move_flag (
        .clk    (rx_clk),
        .rst_n  (rx_rst_n),
        .set_i  (rx_moved),
        .clr_i  (irq_clr),
        .flag_o (move_irq)
    );

    fpt_slot_timer #(.FRAME_LEN(FRAME_LEN), .SLOT_W(SLOT_W)) u_tx_timer (
        .clk     (tx_clk),
        .rst_n   (tx_rst_n),
        .pulse_i (tx_pulse),
        .slot_o  (tx_slot),
        .frame_o (tx_frame)
    );

    fpt_phase_check u_phase (
        .clk   (tx_clk),
        .rst_n (tx_rst_n),
        .en_i  (ext_tx_en),
        .ext_i (ext_tx_fp),
        .ref_i (ref_fp),
        .err_o (tx_phase_err)
    );

    // Without a receive pulse the flag cannot rise, so missing pulses and
    // transmit pulses are both silent (R3, R10).
    p_missing_quiet_r3: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        (!rx_fp && !move_irq) |=> !move_irq);

    p_held_pinned_r8: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        (rx_fp && $past(rx_fp)) |-> (rx_slot == '0) && rx_frame);

endmodule

// File: tb/frame_pulse_tracker_bench.sv
module frame_pulse_tracker_bench;

    localparam int LEN = 8;
    localparam int W   = 3;

    logic         clk = 1'b0;
    logic         rx_rst_n, tx_rst_n;
    logic         rx_fp, irq_clr, ext_tx_en, ext_tx_fp, ref_fp;
    logic [W-1:0] rx_slot, tx_slot;
    logic         rx_frame, move_irq, tx_frame, tx_phase_err;

    always #5 clk = ~clk;

    frame_pulse_tracker #(.FRAME_LEN(LEN)) u_frame_pulse_tracker (
        .rx_clk(clk), .rx_rst_n(rx_rst_n), .rx_fp(rx_fp), .irq_clr(irq_clr),
        .rx_slot(rx_slot), .rx_frame(rx_frame), .move_irq(move_irq),
        .tx_clk(clk), .tx_rst_n(tx_rst_n), .ext_tx_en(ext_tx_en),
        .ext_tx_fp(ext_tx_fp), .ref_fp(ref_fp),
        .tx_slot(tx_slot), .tx_frame(tx_frame), .tx_phase_err(tx_phase_err)
    );

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    int    rx_anchor = 0;
    int    tx_anchor = 0;
    bit    acq = 0;
    bit    e_irq = 0;
    bit    e_err = 0;
    bit    en = 0;
    bit    done = 0;
    string req = "R1";

    function automatic int rx_exp();
        return (cyc - rx_anchor) % LEN;
    endfunction

    function automatic int tx_exp();
        return (cyc - tx_anchor) % LEN;
    endfunction

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic verify();
        check("rx_slot", int'(rx_slot), rx_exp());
        check("rx_frame", int'(rx_frame), (cyc > 0 && rx_exp() == 0) ? 1 : 0);
        check("move_irq", int'(move_irq), int'(e_irq));
        check("tx_slot", int'(tx_slot), tx_exp());
        check("tx_frame", int'(tx_frame), (cyc > 0 && tx_exp() == 0) ? 1 : 0);
        check("tx_phase_err", int'(tx_phase_err), int'(e_err));
    endtask

    // One clock: drive inputs, predict the next state, sample after the edge.
    task automatic tick(bit rfp, bit clr, bit xfp, bit rf);
        bit moved;
        rx_fp = rfp; irq_clr = clr; ext_tx_fp = xfp; ref_fp = rf; ext_tx_en = en;
        moved = rfp && acq && (rx_exp() != LEN - 1);
        if (moved)    e_irq = 1'b1;
        else if (clr) e_irq = 1'b0;
        if (!en)            e_err = 1'b0;
        else if (xfp || rf) e_err = xfp ^ rf;
        if (rfp) begin acq = 1'b1; rx_anchor = cyc + 1; end
        if (en && xfp) tx_anchor = cyc + 1;
        @(posedge clk);
        #2;
        cyc++;
        verify();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0);
    endtask

    task automatic run_to_rx(int s);
        while (rx_exp() != s) tick(0, 0, 0, 0);
    endtask

    task automatic run_to_tx(int s);
        while (tx_exp() != s) tick(0, 0, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < 50000; i++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rx_rst_n = 0; tx_rst_n = 0;
        rx_fp = 0; irq_clr = 0; ext_tx_en = 0; ext_tx_fp = 0; ref_fp = 0;
        repeat (3) @(posedge clk);
        #2;
        rx_rst_n = 1; tx_rst_n = 1;
        // R1: reset state
        req = "R1";
        verify();

        // R2: free-run count and wrap
        req = "R2";
        idle(3 * LEN + 2);

        // R6: first pulse at a non-boundary slot only aligns
        req = "R6";
        run_to_rx(3);
        tick(1, 0, 0, 0);
        idle(3);

        // R4: on-time pulses over several frames
        req = "R4";
        for (int f = 0; f < 3; f++) begin
            run_to_rx(LEN - 1);
            tick(1, 0, 0, 0);
        end
        idle(2);

        // R3: pulses go missing for three frames
        req = "R3";
        idle(3 * LEN);

        // R5 / R4: pulse at every slot position, clearing between
        for (int p = 0; p < LEN; p++) begin
            req = "R7";
            tick(0, 1, 0, 0);
            req = (p == LEN - 1) ? "R4" : "R5";
            run_to_rx(p);
            tick(1, 0, 0, 0);
            idle(2);
        end

        // R7: clear, then clear coinciding with a moved pulse
        req = "R7";
        idle(4);
        tick(0, 1, 0, 0);
        idle(3);
        run_to_rx(2);
        tick(1, 0, 0, 0);
        idle(2);
        tick(0, 1, 0, 0);
        run_to_rx(4);
        tick(1, 1, 0, 0);
        idle(3);

        // R8: pulse held high
        req = "R8";
        for (int i = 0; i < 12; i++) tick(1, 0, 0, 0);
        idle(LEN + 2);
        req = "R7";
        tick(0, 1, 0, 0);

        // R9: internal transmit timing ignores external pulses
        req = "R9";
        en = 0;
        run_to_tx(2);
        tick(0, 0, 1, 0);
        idle(3);
        tick(0, 0, 1, 1);
        tick(0, 0, 0, 1);
        idle(LEN);

        // R10: external transmit framing, realign and free-run, irq untouched
        req = "R10";
        en = 1;
        run_to_tx(3);
        tick(0, 0, 1, 1);
        idle(3 * LEN);
        run_to_tx(5);
        tick(0, 0, 1, 1);
        idle(4);
        for (int i = 0; i < 5; i++) tick(0, 0, 1, 1);
        idle(LEN);

        // R11: phase status under the four pulse combinations
        req = "R11";
        run_to_tx(LEN - 1);
        tick(0, 0, 1, 0);
        idle(3);
        tick(0, 0, 1, 1);
        idle(2);
        tick(0, 0, 0, 1);
        idle(2);
        tick(0, 0, 1, 1);
        tick(0, 0, 0, 1);
        tick(0, 0, 1, 0);
        idle(2);

        // R9: mode off clears status
        req = "R9";
        en = 0;
        tick(0, 0, 0, 0);
        tick(0, 0, 1, 0);
        idle(2);

        // R1: reset again from a busy state
        req = "R1";
        en = 1;
        tick(1, 0, 1, 0);
        rx_rst_n = 0; tx_rst_n = 0;
        @(posedge clk);
        #2;
        rx_rst_n = 1; tx_rst_n = 1;
        cyc = 0; rx_anchor = 0; tx_anchor = 0; acq = 0; e_irq = 0; e_err = 0;
        verify();
        req = "R6";
        run_to_rx(5);
        tick(1, 0, 0, 0);
        idle(2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule